// File: doc/BRIEF.md
# Cascaded Delay Chain Default Loader

This block brings a string of ten programmable delay devices to their default settings. The devices share one serial load path: each device's serial output feeds the serial input of the next device. The block therefore sends one unbroken frame that holds every device's code and then pulses a load strobe, which makes all devices take their new value at once. Because the devices form one chain, changing any single delay means sending the whole frame again.

A load runs by itself when the reset is released. It runs again each time the reload request input is pulsed, which is how a board-level reset reaches the block. The default codes come from a parameter vector. Device `i` (counting from 1) takes bits `[(i-1)*8 +: 8]`. When a load finishes, the `done` flag is raised and the three serial lines are handed to an external host. The host can then send its own frames to adjust the delays.

The serial clock is the system clock divided by `CLK_DIV`. Each bit period begins with the serial clock low and ends with it high. Data moves only at the start of a bit period.

Top module: `dly_chain_loader`

## Requirements
- R1: While `rstN` is low, `done`, `serLoad` and `serClk` are all 0. When reset is released, a default load starts with no other stimulus.
- R2: Every load frame contains exactly 80 rising edges of `serClk` (10 devices × 8 bits) before the latch pulse.
- R3: The code for device 10 (the reset clock) is sent first and the code for device 1 (the data clock) is sent last. Each code is sent with its most significant bit first. The chain order from device 1 to device 10 is: data clock, channel-2 sample-pedestal, channel-1 sample-pedestal, channel-2 sample-data, channel-1 sample-data, H1A, H1B, H2A, H2B, reset clock.
- R4: During a frame, each bit period lasts `CLK_DIV` system cycles. Within it, `serClk` is low for the first `CLK_DIV/2` cycles and high for the rest, so consecutive rising edges are exactly `CLK_DIV` cycles apart.
- R5: During a frame, `serData` changes only when `serClk` falls or while it is low. It never changes while `serClk` stays high.
- R6: `serLoad` is low during the shift. After the last bit it is high for exactly `CLK_DIV` system cycles, and `serClk` stays low throughout that pulse.
- R7: `done` rises in the first cycle after the latch pulse ends. It stays high until the next reload request.
- R8: While `done` is high, `serLoad`, `serData` and `serClk` follow `hostLoad`, `hostData` and `hostClk` respectively.
- R9: While a load is running, the host inputs have no effect on the three serial outputs.
- R10: A reload request during a load, whether in the shift or in the latch pulse, restarts the frame from its first bit. In the next cycle `done`, `serLoad` and `serClk` are 0, and a complete frame of 80 bits follows.
- R11: A reload request after `done` is high starts a complete new frame with the same default codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; its release starts a load |
| reloadReq | input | 1 | Synchronous request to restart the default load |
| hostLoad | input | 1 | Host load strobe, passed through when idle |
| hostData | input | 1 | Host serial data, passed through when idle |
| hostClk | input | 1 | Host serial clock, passed through when idle |
| serLoad | output | 1 | Load strobe to the delay chain |
| serData | output | 1 | Serial data to the first device of the chain |
| serClk | output | 1 | Serial clock to the delay chain |
| done | output | 1 | High once the default load has been latched |

## Verification
The hardest situation to bring about is a reload request that lands inside the four-cycle latch pulse. In that case the frame has been fully shifted but not yet taken, and `done` must not rise. The bench counts system cycles from the start of a frame to find that window: 80 bit periods plus one cycle. It issues the request there, then checks that a full, correctly ordered 80-bit frame follows. A second restart is placed in the middle of the shift. During a further load, the host lines toggle every cycle, which checks that they cannot leak into the frame.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef struct packed {
    logic loadFrame;   // reload the shift register with the default codes
    logic shiftBit;    // advance to the next bit of the frame
    logic hostSel;     // hand the serial lines to the host
    logic clkLvl;      // internal serial clock level
    logic latchLvl;    // internal load strobe level
  } dclStrobeT;

  typedef enum logic [1:0] {
    ST_SHIFT = 2'd0,
    ST_LATCH = 2'd1,
    ST_IDLE  = 2'd2
  } dclStateT;
endpackage

// File: rtl/dcl_ctrl.sv
module dcl_ctrl
  import dcl_pkg::*;
#(
  parameter int NUM_DEV = 10,
  parameter int CODE_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reloadReq,
  output dclStrobeT strobe,
  output logic      done
);
  localparam int FRAME_BITS = NUM_DEV * CODE_W;
  localparam int BIT_W      = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam int PH_W       = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  dclStateT         state;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitCnt;
  logic             endPh;

  assign endPh = (phase == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_SHIFT;
      phase  <= '0;
      bitCnt <= '0;
    end else if (reloadReq) begin
      state  <= ST_SHIFT;
      phase  <= '0;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_SHIFT: begin
          phase <= endPh ? '0 : phase + 1'b1;
          if (endPh) begin
            if (bitCnt == BIT_LAST) state <= ST_LATCH;
            else                    bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_LATCH: begin
          phase <= endPh ? '0 : phase + 1'b1;
          if (endPh) state <= ST_IDLE;
        end
        default: begin
          phase <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.loadFrame = reloadReq;
    strobe.shiftBit  = (state == ST_SHIFT) && endPh && !reloadReq;
    strobe.hostSel   = (state == ST_IDLE);
    strobe.clkLvl    = (state == ST_SHIFT) && (phase >= PH_HALF);
    strobe.latchLvl  = (state == ST_LATCH);
  end

  assign done = (state == ST_IDLE);
endmodule

// File: rtl/dcl_datapath.sv
module dcl_datapath
  import dcl_pkg::*;
#(
  parameter int NUM_DEV = 10,
  parameter int CODE_W  = 8,
  parameter logic [NUM_DEV*CODE_W-1:0] DEFAULT_CODES = '0
) (
  input  logic      clk,
  input  logic      rstN,
  input  dclStrobeT strobe,
  input  logic      hostLoad,
  input  logic      hostData,
  input  logic      hostClk,
  output logic      serLoad,
  output logic      serData,
  output logic      serClk
);
  localparam int FRAME_BITS = NUM_DEV * CODE_W;

  // The last device sits in the top bits, so shifting left from the top
  // sends the last device first and each code MSB first.
  logic [FRAME_BITS-1:0] frameSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 frameSr <= DEFAULT_CODES;
    else if (strobe.loadFrame) frameSr <= DEFAULT_CODES;
    else if (strobe.shiftBit)  frameSr <= {frameSr[FRAME_BITS-2:0], 1'b0};
  end

  always_comb begin
    if (strobe.hostSel) begin
      serLoad = hostLoad;
      serData = hostData;
      serClk  = hostClk;
    end else begin
      serLoad = strobe.latchLvl;
      serData = frameSr[FRAME_BITS-1];
      serClk  = strobe.clkLvl;
    end
  end
endmodule

// File: rtl/dly_chain_loader.sv
module dly_chain_loader
  import dcl_pkg::*;
#(
  parameter int NUM_DEV = 10,
  parameter int CODE_W  = 8,
  parameter int CLK_DIV = 4,
  parameter logic [NUM_DEV*CODE_W-1:0] DEFAULT_CODES =
    80'h5A_C3_81_7E_24_F0_0F_99_A5_3C
) (
  input  logic clk,
  input  logic rstN,
  input  logic reloadReq,
  input  logic hostLoad,
  input  logic hostData,
  input  logic hostClk,
  output logic serLoad,
  output logic serData,
  output logic serClk,
  output logic done
);
  dclStrobeT strobe;

  dcl_ctrl #(.NUM_DEV(NUM_DEV), .CODE_W(CODE_W), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .reloadReq(reloadReq), .strobe(strobe), .done(done)
  );

  dcl_datapath #(.NUM_DEV(NUM_DEV), .CODE_W(CODE_W), .DEFAULT_CODES(DEFAULT_CODES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostLoad(hostLoad), .hostData(hostData), .hostClk(hostClk),
    .serLoad(serLoad), .serData(serData), .serClk(serClk)
  );
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic reloadReq,
  input logic hostLoad,
  input logic hostData,
  input logic hostClk,
  input logic serLoad,
  input logic serData,
  input logic serClk,
  input logic done
);
  int latchRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 latchRun <= 0;
    else if (serLoad && !done) latchRun <= latchRun + 1;
    else                       latchRun <= 0;
  end

  p_latch_clk_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (serLoad && !done) |-> !serClk);

  p_latch_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    latchRun <= CLK_DIV);

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!done && $past(!done) && serClk && $past(serClk)) |-> $stable(serData));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !reloadReq) |=> done);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |=> (!done && !serLoad && !serClk));

  p_passthru_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (serLoad == hostLoad && serData == hostData && serClk == hostClk));
endmodule

bind dly_chain_loader dcl_checker #(.CLK_DIV(CLK_DIV)) u_dcl_checker (
  .clk(clk), .rstN(rstN), .reloadReq(reloadReq),
  .hostLoad(hostLoad), .hostData(hostData), .hostClk(hostClk),
  .serLoad(serLoad), .serData(serData), .serClk(serClk), .done(done)
);

// File: tb/sim_dly_chain_loader.sv
`timescale 1ns/1ps
module sim_dly_chain_loader;
  localparam int NDEV = 10;
  localparam int CW   = 8;
  localparam int DIV  = 4;
  localparam int NB   = NDEV * CW;

  function automatic logic [7:0] devCode(int d);
    return 8'(((d * 37) + 11) ^ (d << 4));
  endfunction

  function automatic logic [NB-1:0] buildCodes();
    logic [NB-1:0] r;
    r = '0;
    for (int d = 1; d <= NDEV; d++) r[(d-1)*CW +: CW] = devCode(d);
    return r;
  endfunction

  localparam logic [NB-1:0] CODES = buildCodes();

  logic clk = 0, rstN = 0, reloadReq = 0;
  logic hostLoad = 0, hostData = 0, hostClk = 0;
  logic serLoad, serData, serClk, done;

  dly_chain_loader #(.NUM_DEV(NDEV), .CODE_W(CW), .CLK_DIV(DIV), .DEFAULT_CODES(CODES)) u0 (
    .clk(clk), .rstN(rstN), .reloadReq(reloadReq),
    .hostLoad(hostLoad), .hostData(hostData), .hostClk(hostClk),
    .serLoad(serLoad), .serData(serData), .serClk(serClk), .done(done)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor, sampling on the falling system clock edge
  int cyc = 0, lastRise = 0, nBits = 0, gapBad = 0, edgeBad = 0;
  int latchLen = 0, latchClkBad = 0;
  int seenBits = 0, seenLatch = 0;
  logic [NB-1:0] cap = '0, seenCap = '0;
  logic prevClk = 0, prevData = 0, prevLoad = 0, prevDone = 0, skip = 0;
  logic frameSeen = 0, doneOk = 0;

  task automatic clearMon();
    nBits = 0; gapBad = 0; edgeBad = 0; latchLen = 0; latchClkBad = 0;
    cap = '0; frameSeen = 0; doneOk = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (reloadReq) begin
        clearMon();
        skip = 1;
      end else begin
        if (!done && !skip) begin
          if (!prevClk && serClk) begin
            if (nBits > 0 && (cyc - lastRise) != DIV) gapBad++;
            lastRise = cyc;
            cap = {cap[NB-2:0], serData};
            nBits++;
          end
          if (prevClk && serClk && serData != prevData) edgeBad++;
          if (serLoad) begin
            latchLen++;
            if (serClk) latchClkBad++;
          end
        end
        if (prevLoad && !serLoad && !prevDone && !skip) begin
          frameSeen = 1; doneOk = done; seenBits = nBits;
          seenCap = cap; seenLatch = latchLen;
        end
        skip = 0;
      end
    end
    prevClk = serClk; prevData = serData; prevLoad = serLoad; prevDone = done;
  end

  task automatic pulseReload();
    @(posedge clk); #1 reloadReq = 1;
    @(posedge clk); #1 reloadReq = 0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, {tag, " load finished"}, done, 1);
  endtask

  task automatic checkFrame(input string tag);
    @(negedge clk);
    chk(frameSeen, {tag, " R7 done rises as latch ends"}, frameSeen, 1);
    chk(doneOk, {tag, " R7 done in cycle after latch"}, doneOk, 1);
    chk(seenBits == NB, {tag, " R2 bit count"}, seenBits, NB);
    for (int d = 1; d <= NDEV; d++)
      chk(seenCap[(d-1)*CW +: CW] == devCode(d), {tag, " R3 device code order"},
          seenCap[(d-1)*CW +: CW], devCode(d));
    chk(gapBad == 0, {tag, " R4 serial clock period"}, gapBad, 0);
    chk(edgeBad == 0, {tag, " R5 data stable while clock high"}, edgeBad, 0);
    chk(seenLatch == DIV, {tag, " R6 latch width"}, seenLatch, DIV);
    chk(latchClkBad == 0, {tag, " R6 clock low in latch"}, latchClkBad, 0);
    clearMon();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!done && !serLoad && !serClk, "R1 reset outputs", {done, serLoad, serClk}, 0);
    @(posedge clk); #1 rstN = 1;
    waitDone("R1 power-up");
    checkFrame("R1 power-up");

    // R8 pass-through sweep over all host combinations
    for (int v = 0; v < 8; v++) begin
      @(posedge clk); #1 {hostLoad, hostData, hostClk} = 3'(v);
      @(negedge clk);
      chk({serLoad, serData, serClk} == 3'(v), "R8 pass-through", {serLoad, serData, serClk}, v);
      chk(done, "R7 done held while idle", done, 1);
    end
    @(posedge clk); #1 {hostLoad, hostData, hostClk} = 3'b000;

    // R11 reload after done; R9 host toggling while loading
    pulseReload();
    @(negedge clk);
    chk(!done && !serLoad && !serClk, "R11 reload starts frame", {done, serLoad, serClk}, 0);
    for (int i = 0; i < NB * DIV; i++) begin
      @(posedge clk); #1 {hostLoad, hostData, hostClk} = 3'((i * 5 + 3) ^ (i >> 2));
    end
    @(posedge clk); #1 {hostLoad, hostData, hostClk} = 3'b000;
    waitDone("R9 host toggling");
    checkFrame("R9 host ignored");

    // R10 restart in the middle of the shift
    pulseReload();
    repeat (137) @(posedge clk);
    pulseReload();
    @(negedge clk);
    chk(!done && !serLoad && !serClk, "R10 restart outputs", {done, serLoad, serClk}, 0);
    waitDone("R10 mid-shift");
    checkFrame("R10 mid-shift restart");

    // R10 restart inside the latch pulse
    pulseReload();
    repeat (NB * DIV) @(posedge clk);
    @(negedge clk);
    chk(serLoad && !done, "R10 reached latch window", serLoad, 1);
    pulseReload();
    @(negedge clk);
    chk(!done && !serLoad, "R10 latch restart outputs", {done, serLoad}, 0);
    waitDone("R10 latch");
    checkFrame("R10 latch restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule